// File: doc/BRIEF.md
# SPI Slave Register Port with Read/Write Handshake

This block is an SPI target that lets an external host reach two 8-bit registers, a data register and a status register. Each transaction starts with a direction bit and a register-select bit. A data byte follows, most significant bit first. The slave then returns one handshake bit on SDO. On a read of the data register, the handshake bit says whether the byte was new or a repeat of the previous one. On a write to the data register, it says whether the byte was taken or dropped because the downstream buffer was full.

The block runs entirely in the system clock domain. SCLK, SDI and CS pass through multi-flop synchronizers and are oversampled, so the system clock must run at least 8 times faster than SCLK. SDI is captured on rising SCLK edges and SDO changes on falling edges. Behind the data register sit two byte streams:
- The fetch stream carries bytes that the host reads. The block pops it with a one-cycle `fetch_ready` strobe.
- The store stream carries bytes that the host writes. The block pushes into it with a one-cycle `store_valid` pulse.

Back-pressure on the store side is handled by sampling `store_ready` when the last data bit arrives. A byte that meets a low `store_ready` is dropped, and the host learns this from the handshake bit. On the fetch side the producer must follow one rule: once `fetch_valid` is high, it keeps `fetch_valid` high and `fetch_data` stable until it sees `fetch_ready`.

Top module: `spi_regslave`

## Requirements
- R1: A frame exists only while CS is high. Bits are counted on rising SCLK edges from the moment CS rises. CS must be low for at least one SCLK period between frames.
- R2: The first bit of a frame selects the direction (1 = host reads, 0 = host writes). The second bit selects the register (0 = data, 1 = status). A frame moves at most one byte through the stream ports.
- R3: The 8 data bits follow directly after the select bit, MSB first. They are driven on SDO for reads and sampled from SDI for writes.
- R4: A write to the data register commits on the rising edge that captures the last data bit. If `store_ready` is high at that point, the block raises `store_valid` for exactly one cycle with the byte on `store_data`, and the handshake bit is 0.
- R5: A read of the data register while `fetch_valid` is high at the select bit returns `fetch_data` and has handshake bit 0. It also pops the fetch stream with exactly one `fetch_ready` cycle when the frame commits.
- R6: A write to the data register while `store_ready` is low at commit drops the byte with no push, and the handshake bit is 1.
- R7: A read of the data register while `fetch_valid` is low at the select bit repeats the last byte delivered (0 after reset). Its handshake bit is 1 and it does not pop.
- R8: The status byte reports these fields; all other bits read 0:
  - bit 0: fetch stream empty (1 = no byte available)
  - bit 1: store stream full (1 = `store_ready` low)
  - bit 2: read-interrupt enable
  - bit 3: write-interrupt enable
- R9: A write to the status register updates only the two enable bits (from data bits 2 and 3). It pushes nothing and its handshake bit is 0.
- R10: If CS falls before the last data bit is captured, the frame is abandoned: no push, no pop, no enable update. The next frame starts again at the direction bit.
- R11: After reset SDO is 0, `fetch_ready` and `store_valid` are 0, and both enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs | input | 1 | Chip select, active high |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data and handshake bit to host |
| fetch_valid | input | 1 | Fetch stream has a byte for the host |
| fetch_data | input | 8 | Byte at the head of the fetch stream |
| fetch_ready | output | 1 | One-cycle pop of the fetch stream |
| store_valid | output | 1 | One-cycle push into the store stream |
| store_data | output | 8 | Byte written by the host |
| store_ready | input | 1 | Store stream can take a byte |

## Verification
Two situations are the hardest to reach from the pins.

The first is a frame abandoned part-way through. The bench reaches it with a frame task that takes a bit count and drops CS after 6 bits of a write and after 5 bits of a read. It then proves that no push or pop occurred, and that the next complete frame is framed correctly.

The second is the pair of full-buffer and stale-data handshake outcomes. These depend on the stream state at two specific bit positions. The bench reaches them by holding `store_ready` low through an entire write frame and by draining its fetch model before a read. It then reads the handshake bit off SDO at the eleventh clock.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  typedef enum logic {SEL_DATA = 1'b0, SEL_STAT = 1'b1} sel_e;

  // status byte field positions
  localparam int ST_FETCH_EMPTY = 0;
  localparam int ST_STORE_FULL  = 1;
  localparam int ST_RD_IE       = 2;
  localparam int ST_WR_IE       = 3;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rs_status.sv
module spi_rs_status
  import spi_rs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic          store_ready,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] stat_byte
);
  logic rd_ie_q, wr_ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ie_q <= 1'b0;
      wr_ie_q <= 1'b0;
    end else if (wr) begin
      rd_ie_q <= wdata[ST_RD_IE];
      wr_ie_q <= wdata[ST_WR_IE];
    end
  end

  always_comb begin
    stat_byte                 = '0;
    stat_byte[ST_FETCH_EMPTY] = ~fetch_valid;
    stat_byte[ST_STORE_FULL]  = ~store_ready;
    stat_byte[ST_RD_IE]       = rd_ie_q;
    stat_byte[ST_WR_IE]       = wr_ie_q;
  end

  AST_IE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rd_ie_q, wr_ie_q}) |-> $past(wr)) else $error("enable bits moved without write"); // R9
endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame
  import spi_rs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_q,
  input  logic          sclk_q,
  input  logic          sdi_q,
  output logic          sdo,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_data,
  output logic          fetch_ready,
  input  logic          store_ready,
  output logic          store_valid,
  output logic [DW-1:0] store_data,
  input  logic [DW-1:0] stat_byte,
  output logic          stat_wr,
  output logic [DW-1:0] stat_wdata
);
  localparam int CW = $clog2(DW + 4);
  localparam logic [CW-1:0] C_SEL  = CW'(1);
  localparam logic [CW-1:0] C_D0   = CW'(2);
  localparam logic [CW-1:0] C_LAST = CW'(DW + 1);
  localparam logic [CW-1:0] C_HS   = CW'(DW + 2);
  localparam logic [CW-1:0] C_TOP  = CW'(DW + 3);

  logic          sclk_d;
  logic          rise, fall, commit;
  logic [CW-1:0] cnt;
  logic          dir_q, fresh_q, hs_q;
  sel_e          sel_q;
  logic [DW-1:0] rxsr, txsr, hold_q, last_q;
  logic [DW-1:0] wbyte;
  logic [DW-1:0] rd_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_q;
  end

  assign rise    = cs_q &  sclk_q & ~sclk_d;
  assign fall    = cs_q & ~sclk_q &  sclk_d;
  assign commit  = rise && (cnt == C_LAST);
  assign wbyte   = {rxsr[DW-2:0], sdi_q};
  assign rd_pick = fetch_valid ? fetch_data : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      dir_q   <= 1'b0;
      sel_q   <= SEL_DATA;
      fresh_q <= 1'b0;
      hs_q    <= 1'b0;
      rxsr    <= '0;
      txsr    <= '0;
      hold_q  <= '0;
      last_q  <= '0;
      sdo     <= 1'b0;
    end else if (!cs_q) begin
      cnt <= '0;
      sdo <= 1'b0;
    end else if (rise) begin
      if (cnt != C_TOP) cnt <= cnt + 1'b1;
      if (cnt == '0) dir_q <= sdi_q;
      if (cnt == C_SEL) begin
        sel_q <= sel_e'(sdi_q);
        if (dir_q) begin
          if (sel_e'(sdi_q) == SEL_STAT) begin
            txsr    <= stat_byte;
            fresh_q <= 1'b0;
          end else begin
            txsr    <= rd_pick;
            hold_q  <= rd_pick;
            fresh_q <= fetch_valid;
          end
        end else begin
          txsr    <= '0;
          fresh_q <= 1'b0;
        end
      end
      if (cnt >= C_D0) rxsr <= wbyte;
      if (commit) begin
        if (dir_q) begin
          hs_q <= (sel_q == SEL_DATA) & ~fresh_q;
          if ((sel_q == SEL_DATA) && fresh_q) last_q <= hold_q;
        end else begin
          hs_q <= (sel_q == SEL_DATA) & ~store_ready;
        end
      end
    end else if (fall) begin
      if ((cnt >= C_D0) && (cnt <= C_LAST)) begin
        sdo  <= txsr[DW-1];
        txsr <= {txsr[DW-2:0], 1'b0};
      end else if (cnt == C_HS) begin
        sdo <= hs_q;
      end else begin
        sdo <= 1'b0;
      end
    end
  end

  assign fetch_ready = commit &  dir_q & (sel_q == SEL_DATA) & fresh_q;
  assign store_valid = commit & ~dir_q & (sel_q == SEL_DATA) & store_ready;
  assign store_data  = wbyte;
  assign stat_wr     = commit & ~dir_q & (sel_q == SEL_STAT);
  assign stat_wdata  = wbyte;

  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_ready, store_valid, stat_wr})) else $error("two transfers in one frame"); // R2
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_valid) else $error("pop of empty fetch stream"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> (!sdo && (cnt == '0))) else $error("state kept after deselect"); // R10
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !dir_q && (sel_q == SEL_DATA) && !store_ready) |=> hs_q) else $error("full write not flagged"); // R6
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs,
  input  logic          spi_sdi,
  output logic          spi_sdo,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_data,
  output logic          fetch_ready,
  output logic          store_valid,
  output logic [DW-1:0] store_data,
  input  logic          store_ready
);
  logic          sclk_q, sdi_q, cs_q;
  logic [DW-1:0] stat_byte, stat_wdata;
  logic          stat_wr;

  spi_rs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs, spi_sdi, spi_sclk}),
    .q     ({cs_q, sdi_q, sclk_q})
  );

  spi_rs_frame #(.DW(DW)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_q        (cs_q),
    .sclk_q      (sclk_q),
    .sdi_q       (sdi_q),
    .sdo         (spi_sdo),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .fetch_ready (fetch_ready),
    .store_ready (store_ready),
    .store_valid (store_valid),
    .store_data  (store_data),
    .stat_byte   (stat_byte),
    .stat_wr     (stat_wr),
    .stat_wdata  (stat_wdata)
  );

  spi_rs_status #(.DW(DW)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .store_ready (store_ready),
    .wr          (stat_wr),
    .wdata       (stat_wdata),
    .stat_byte   (stat_byte)
  );
endmodule

// File: tb/tb_spi_regslave.sv
module tb_spi_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;   // system clocks per SCLK half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs = 1'b0, sdi = 1'b0;
  logic       sdo;
  logic       fetch_valid, fetch_ready;
  logic [7:0] fetch_data;
  logic       store_valid, store_ready = 1'b1;
  logic [7:0] store_data;

  logic [7:0] src [8];
  int         src_n = 0, src_idx = 0;
  logic [7:0] got [8];
  int         got_n = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fetch_valid = (src_idx < src_n);
  assign fetch_data  = src[src_idx[2:0]];

  always @(posedge clk) begin
    if (fetch_valid && fetch_ready) src_idx <= src_idx + 1;
    if (store_valid) begin
      got[got_n[2:0]] <= store_data;
      got_n <= got_n + 1;
    end
  end

  spi_regslave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs(cs), .spi_sdi(sdi), .spi_sdo(sdo),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .store_valid(store_valid), .store_data(store_data), .store_ready(store_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one frame; nbits < 11 drops CS early
  task automatic frame(input bit dir, input bit sel, input logic [7:0] wb, input int nbits,
                       output logic [7:0] rb, output logic hs);
    rb = '0; hs = 1'b0;
    cs = 1'b1;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == 0)      sdi = dir;
      else if (i == 1) sdi = sel;
      else if (i <= 9) sdi = wb[9-i];
      else             sdi = 1'b0;
      tick(HALF);
      if (i >= 2 && i <= 9) rb[9-i] = sdo;
      if (i == 10)          hs = sdo;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs = 1'b0;
    sdi = 1'b0;
    tick(2*HALF);
  endtask

  task automatic t_reset;
    logic [7:0] rb; logic hs;
    chk(sdo == 1'b0, "R11 sdo idle", sdo, 0);
    chk(fetch_ready == 1'b0 && store_valid == 1'b0, "R11 strobes idle", {fetch_ready, store_valid}, 0);
    frame(1, 1, 8'h00, 11, rb, hs);
    chk(rb == 8'h01, "R11/R8 status after reset", rb, 8'h01);
    frame(1, 0, 8'h00, 11, rb, hs);
    chk(rb == 8'h00 && hs == 1'b1, "R7 stale read after reset", {hs, rb}, 9'h100);
  endtask

  task automatic t_write_ok;
    logic [7:0] rb; logic hs;
    store_ready = 1'b1;
    frame(0, 0, 8'hA5, 11, rb, hs);
    chk(hs == 1'b0, "R4 write handshake", hs, 0);
    chk(got_n == 1 && got[0] == 8'hA5, "R1/R3 write byte", got[0], 8'hA5);
    frame(0, 0, 8'h5A, 11, rb, hs);
    chk(got_n == 2 && got[1] == 8'h5A, "R4 second write", got[1], 8'h5A);
  endtask

  task automatic t_write_full;
    logic [7:0] rb; logic hs;
    store_ready = 1'b0;
    frame(0, 0, 8'h77, 11, rb, hs);
    chk(hs == 1'b1, "R6 full handshake", hs, 1);
    chk(got_n == 2, "R6 no push when full", got_n, 2);
    store_ready = 1'b1;
  endtask

  task automatic t_read_fresh;
    logic [7:0] rb; logic hs;
    src[0] = 8'h3C; src[1] = 8'hC3; src_n = 2;
    frame(1, 0, 8'h00, 11, rb, hs);
    chk(rb == 8'h3C && hs == 1'b0, "R5/R3 first read", {hs, rb}, 9'h03C);
    chk(src_idx == 1, "R5 one pop", src_idx, 1);
    frame(1, 0, 8'h00, 11, rb, hs);
    chk(rb == 8'hC3 && hs == 1'b0, "R5 second read", {hs, rb}, 9'h0C3);
  endtask

  task automatic t_read_stale;
    logic [7:0] rb; logic hs;
    frame(1, 0, 8'h00, 11, rb, hs);
    chk(rb == 8'hC3 && hs == 1'b1, "R7 stale repeat", {hs, rb}, 9'h1C3);
    chk(src_idx == 2, "R7 no pop when empty", src_idx, 2);
  endtask

  task automatic t_status;
    logic [7:0] rb; logic hs;
    src[2] = 8'h81; src_n = 3;
    store_ready = 1'b0;
    frame(1, 1, 8'h00, 11, rb, hs);
    chk(rb == 8'h02 && hs == 1'b0, "R8 status avail+full", {hs, rb}, 9'h002);
    store_ready = 1'b1;
    frame(0, 1, 8'hFF, 11, rb, hs);
    chk(hs == 1'b0 && got_n == 2, "R9 status write no push", {hs, got_n[7:0]}, 9'h002);
    frame(1, 1, 8'h00, 11, rb, hs);
    chk(rb == 8'h0C, "R9 enables set", rb, 8'h0C);
    frame(0, 1, 8'h04, 11, rb, hs);
    frame(1, 1, 8'h00, 11, rb, hs);
    chk(rb == 8'h04, "R9 read enable only", rb, 8'h04);
    chk(src_idx == 2, "R2 status read no pop", src_idx, 2);
  endtask

  task automatic t_abort;
    logic [7:0] rb; logic hs;
    frame(0, 0, 8'hEE, 6, rb, hs);
    chk(got_n == 2, "R10 aborted write no push", got_n, 2);
    frame(0, 0, 8'h11, 11, rb, hs);
    chk(got_n == 3 && got[2] == 8'h11, "R10 write after abort", got[2], 8'h11);
    frame(1, 0, 8'h00, 5, rb, hs);
    chk(src_idx == 2, "R10 aborted read no pop", src_idx, 2);
    frame(1, 0, 8'h00, 11, rb, hs);
    chk(rb == 8'h81 && hs == 1'b0, "R10 read after abort", {hs, rb}, 9'h081);
    frame(0, 1, 8'h00, 8, rb, hs);
    frame(1, 1, 8'h00, 11, rb, hs);
    chk(rb == 8'h05, "R10 aborted status write", rb, 8'h05);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin src[i] = '0; got[i] = '0; end
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_ok();
    t_write_full();
    t_read_fresh();
    t_read_stale();
    t_status();
    t_abort();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule